// File: doc/BRIEF.md
# Unaligned Access Splitting Unit

This block takes loads and stores of 1, 2, 4 or 8 bytes at any byte address from a load/store pipeline and serves them over a 32-bit memory bus that only understands word-aligned transactions. It works out how many bus words the access touches. It then issues the aligned transactions and returns one completion. For a load, that completion carries the assembled, right-justified value. For a store, it marks the end of the last bus beat.

An access that starts on a word boundary goes out as a single transaction with a beat count. An access that starts inside a word and runs past it is cut into one single-beat transaction per word touched, issued one after another. Store data is moved onto the byte lanes matching its address, with a byte-enable mask per beat. Load beats are collected and the wanted bytes are pulled out of them.

Only one access is in flight at a time. A new request is taken only after the completion pulse of the previous one.

Top module: `unaligned_split_unit`

## Requirements
- R1: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Byte i of a load result holds memory byte `req_addr + i`, placed in bits [8i+7:8i]. All result bits above the access width are zero.
- R2: Every bus transaction address has its two low bits at zero.
- R3: An access whose address has its two low bits at zero is issued as exactly one transaction. Its `bus_len` equals beats minus one: 0 for widths up to 4 bytes and 1 for 8 bytes. An 8-byte store then takes two beat handshakes, both carrying that start address and length 1.
- R4: An access starting at word offset o (o = 1, 2 or 3) with n bytes is issued as ceil((o+n)/4) transactions. Each has `bus_len` 0, and they go to consecutive word addresses starting at the word holding `req_addr`.
- R5: On a load, `bus_be` and `bus_wdata` are zero. Bytes of returned beats outside the requested range do not reach the result.
- R6: On a store, bit k of `bus_be` is set exactly when lane k of that beat's word lies inside the requested byte range. Data byte i travels on lane (`req_addr` + i) mod 4 of the beat that holds it. Lanes without an enable carry zero, and request data above the access width is ignored.
- R7: While `bus_valid` is high and `bus_ready` is low, the bus request fields stay unchanged on the next cycle.
- R8: `req_ready` is low from acceptance until the completion. `done_valid` is a single-cycle pulse in the cycle after the final bus handshake (store) or the final response beat (load). `done_rdata` is zero for stores.
- R9: After reset, `req_ready` is high and both `bus_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Store data, right-justified |
| bus_valid | output | 1 | Bus transaction or write beat offered |
| bus_ready | input | 1 | Bus takes the offer this cycle |
| bus_write | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Word-aligned transaction address |
| bus_len | output | 2 | Beats in the transaction minus one |
| bus_wdata | output | 32 | Write beat data, lane 0 = lowest address |
| bus_be | output | 4 | Write beat byte enables |
| rsp_valid | input | 1 | Read beat returned |
| rsp_rdata | input | 32 | Read beat data |
| done_valid | output | 1 | Access completion pulse |
| done_rdata | output | 64 | Assembled load result |

## Verification
The bench builds the unit with an 8-bit address so that a 64-byte bus memory model covers every address it uses, and keeps the 32-bit bus. With that size it can sweep every access width against every byte offset from 0 to 7. Each combination is run as a load, then a store, then a load. This reaches the single-word, word-aligned burst, two-word and three-word splits in both directions. The bus model stalls `bus_ready` and delays responses on fixed patterns, so held requests and waiting states come up in every split shape.

// File: rtl/usu_pkg.sv
package usu_pkg;
   localparam int unsigned ACC_DATA_W = 64;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_WAIT = 2'd2
   } usu_state_e;
endpackage

// File: rtl/usu_plan.sv
// Decides how many bus words an access touches and whether it may go as one burst.
module usu_plan #(
   parameter int unsigned LANES = 4,
   parameter int unsigned OFF_W = 2,
   parameter int unsigned CNT_W = 2
) (
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       size,
   output logic [CNT_W-1:0] beats,
   output logic             burst
);
   localparam int unsigned SPAN_W = OFF_W + 4;

   logic [SPAN_W-1:0] span;

   always_comb begin
      span  = SPAN_W'(off) + (SPAN_W'(1) << size) + SPAN_W'(LANES - 1);
      beats = CNT_W'(span / SPAN_W'(LANES));
      burst = (off == '0);
   end
endmodule

// File: rtl/usu_lane_pack.sv
// Moves store data onto its byte lanes and builds the enable stream.
module usu_lane_pack #(
   parameter int unsigned OFF_W    = 2,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned STREAM_W = 96
) (
   input  logic [DATA_W-1:0]     wdata,
   input  logic [OFF_W-1:0]      off,
   input  logic [1:0]            size,
   output logic [STREAM_W-1:0]   stream,
   output logic [STREAM_W/8-1:0] be
);
   localparam int unsigned BE_W = STREAM_W / 8;

   logic [DATA_W-1:0] dmask;
   logic [BE_W-1:0]   bmask;
   logic [OFF_W+2:0]  bit_sh;

   always_comb begin
      dmask  = (size == 2'd3) ? '1 : ((DATA_W'(1) << (8 << size)) - DATA_W'(1));
      bmask  = (BE_W'(1) << (1 << size)) - BE_W'(1);
      bit_sh = {off, 3'b000};
      stream = STREAM_W'(wdata & dmask) << bit_sh;
      be     = bmask << off;
   end
endmodule

// File: rtl/usu_lane_merge.sv
// Pulls the requested bytes out of the collected read beats.
module usu_lane_merge #(
   parameter int unsigned OFF_W    = 2,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned STREAM_W = 96
) (
   input  logic [STREAM_W-1:0] stream,
   input  logic [OFF_W-1:0]    off,
   input  logic [1:0]          size,
   output logic [DATA_W-1:0]   rdata
);
   logic [DATA_W-1:0] dmask;
   logic [OFF_W+2:0]  bit_sh;

   always_comb begin
      dmask  = (size == 2'd3) ? '1 : ((DATA_W'(1) << (8 << size)) - DATA_W'(1));
      bit_sh = {off, 3'b000};
      rdata  = DATA_W'(stream >> bit_sh) & dmask;
   end
endmodule

// File: rtl/unaligned_split_unit.sv
module unaligned_split_unit
   import usu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BUS_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [63:0]         req_wdata,
   output logic                bus_valid,
   input  logic                bus_ready,
   output logic                bus_write,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [1:0]          bus_len,
   output logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W/8-1:0]  bus_be,
   input  logic                rsp_valid,
   input  logic [BUS_W-1:0]    rsp_rdata,
   output logic                done_valid,
   output logic [63:0]         done_rdata
);
   localparam int unsigned LANES     = BUS_W / 8;
   localparam int unsigned OFF_W     = $clog2(LANES);
   localparam int unsigned WORD_W    = ADDR_W - OFF_W;
   localparam int unsigned MAX_BYTES = ACC_DATA_W / 8;
   localparam int unsigned MAX_BEATS = (MAX_BYTES + 2 * LANES - 2) / LANES;
   localparam int unsigned STREAM_W  = MAX_BEATS * BUS_W;
   localparam int unsigned BE_W      = MAX_BEATS * LANES;
   localparam int unsigned CNT_W     = 2;

   if (BUS_W != 32) begin : g_bad_bus
      $error("unaligned_split_unit: BUS_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("unaligned_split_unit: ADDR_W must be at least 4");
   end

   usu_state_e          state;
   logic                write_q;
   logic [1:0]          size_q;
   logic [OFF_W-1:0]    off_q;
   logic [WORD_W-1:0]   word_q;
   logic [CNT_W-1:0]    beats_q;
   logic                burst_q;
   logic [CNT_W-1:0]    beat_idx;
   logic [CNT_W-1:0]    rsp_idx;
   logic [STREAM_W-1:0] wstream_q;
   logic [BE_W-1:0]     be_q;
   logic [STREAM_W-1:0] rstream_q;
   logic [STREAM_W-1:0] live_stream;

   logic [CNT_W-1:0]    plan_beats;
   logic                plan_burst;
   logic [STREAM_W-1:0] pack_stream;
   logic [BE_W-1:0]     pack_be;
   logic [63:0]         merged;

   logic accept, bus_take, rsp_take, last_cmd, last_rsp;

   usu_plan #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_plan (
      .off   (req_addr[OFF_W-1:0]),
      .size  (req_size),
      .beats (plan_beats),
      .burst (plan_burst)
   );

   usu_lane_pack #(.OFF_W(OFF_W), .DATA_W(ACC_DATA_W), .STREAM_W(STREAM_W)) u_pack (
      .wdata  (req_wdata),
      .off    (req_addr[OFF_W-1:0]),
      .size   (req_size),
      .stream (pack_stream),
      .be     (pack_be)
   );

   usu_lane_merge #(.OFF_W(OFF_W), .DATA_W(ACC_DATA_W), .STREAM_W(STREAM_W)) u_merge (
      .stream (live_stream),
      .off    (off_q),
      .size   (size_q),
      .rdata  (merged)
   );

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign bus_valid = (state == ST_CMD);
   assign bus_take  = bus_valid && bus_ready;
   assign rsp_take  = (state == ST_WAIT) && rsp_valid;
   assign last_cmd  = (beat_idx == beats_q - CNT_W'(1));
   assign last_rsp  = (rsp_idx == beats_q - CNT_W'(1));

   assign bus_write = bus_valid && write_q;
   assign bus_addr  = {word_q + (burst_q ? WORD_W'(0) : WORD_W'(beat_idx)), {OFF_W{1'b0}}};
   assign bus_len   = (bus_valid && burst_q) ? 2'(beats_q - CNT_W'(1)) : 2'd0;
   assign bus_wdata = bus_write ? wstream_q[beat_idx*BUS_W +: BUS_W] : '0;
   assign bus_be    = bus_write ? be_q[beat_idx*LANES +: LANES] : '0;

   // One slot per bus word: capture its read beat, and feed the merge with
   // the arriving beat already in place on the final response.
   for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rstream_q[g*BUS_W +: BUS_W] <= '0;
         end else if (rsp_take && rsp_idx == CNT_W'(g)) begin
            rstream_q[g*BUS_W +: BUS_W] <= rsp_rdata;
         end
      end
      assign live_stream[g*BUS_W +: BUS_W] =
         (rsp_take && rsp_idx == CNT_W'(g)) ? rsp_rdata : rstream_q[g*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         write_q    <= 1'b0;
         size_q     <= '0;
         off_q      <= '0;
         word_q     <= '0;
         beats_q    <= CNT_W'(1);
         burst_q    <= 1'b0;
         beat_idx   <= '0;
         rsp_idx    <= '0;
         wstream_q  <= '0;
         be_q       <= '0;
         done_valid <= 1'b0;
         done_rdata <= '0;
      end else begin
         done_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               write_q   <= req_write;
               size_q    <= req_size;
               off_q     <= req_addr[OFF_W-1:0];
               word_q    <= req_addr[ADDR_W-1:OFF_W];
               beats_q   <= plan_beats;
               burst_q   <= plan_burst;
               beat_idx  <= '0;
               rsp_idx   <= '0;
               wstream_q <= req_write ? pack_stream : '0;
               be_q      <= req_write ? pack_be : '0;
               state     <= ST_CMD;
            end
            ST_CMD: if (bus_take) begin
               if (!write_q) begin
                  state <= ST_WAIT;
               end else if (last_cmd) begin
                  done_valid <= 1'b1;
                  done_rdata <= '0;
                  state      <= ST_IDLE;
               end else begin
                  beat_idx <= beat_idx + CNT_W'(1);
               end
            end
            ST_WAIT: if (rsp_take) begin
               rsp_idx <= rsp_idx + CNT_W'(1);
               if (last_rsp) begin
                  done_valid <= 1'b1;
                  done_rdata <= merged;
                  state      <= ST_IDLE;
               end else if (!burst_q) begin
                  beat_idx <= beat_idx + CNT_W'(1);
                  state    <= ST_CMD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: every offered transaction is word aligned
   a_r2_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

   // R7: an offer that is not taken stays put
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_len)
                                     && $stable(bus_wdata) && $stable(bus_be)
                                     && $stable(bus_write)));

   // R5: loads never carry enables
   a_r5_read_no_be: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |-> (bus_be == '0 && bus_wdata == '0));

   // R6: every store beat writes at least one lane
   a_r6_write_be: assert property (@(posedge clk) disable iff (!rst_n)
      bus_write |-> (bus_be != '0));

   // R3: a multi-beat store burst writes whole words
   a_r3_burst_full: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_write && bus_len != 2'd0) |-> (bus_be == '1));

   // R8: no new request while the bus side is busy; completion is a pulse
   a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
endmodule

// File: tb/unaligned_split_unit_bench.sv
module unaligned_split_unit_bench;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [63:0]   req_wdata = '0;
   logic          bus_valid;
   logic          bus_ready;
   logic          bus_write;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_len;
   logic [31:0]   bus_wdata;
   logic [3:0]    bus_be;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic          done_valid;
   logic [63:0]   done_rdata;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   logic [7:0] bmem [64];
   logic [7:0] rmem [64];
   int hs_total = 0;
   int len1_total = 0;

   always #2.5 clk = ~clk;

   unaligned_split_unit #(.ADDR_W(AW), .BUS_W(32)) u_unaligned_split_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size, .req_addr,
      .req_wdata, .bus_valid, .bus_ready, .bus_write, .bus_addr, .bus_len,
      .bus_wdata, .bus_be, .rsp_valid, .rsp_rdata, .done_valid, .done_rdata
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] bword(input int a);
      return {bmem[(a + 3) % 64], bmem[(a + 2) % 64], bmem[(a + 1) % 64], bmem[a % 64]};
   endfunction

   // Bus memory model: stalls ready and delays read beats on fixed patterns.
   initial begin
      int cyc = 0;
      int pend_cnt = 0;
      int pend_addr = 0;
      bit wphase = 1'b0;
      bus_ready = 1'b0;
      rsp_valid = 1'b0;
      rsp_rdata = '0;
      for (int i = 0; i < 64; i++) bmem[i] = 8'((i * 37 + 5) % 256);
      forever begin
         @(posedge clk);
         cyc++;
         if (rsp_valid) begin
            pend_cnt--;
            pend_addr += 4;
         end
         if (bus_valid && bus_ready) begin
            hs_total++;
            if (bus_len != 2'd0) len1_total++;
            if (bus_write) begin
               int a;
               a = int'(bus_addr) + ((bus_len != 2'd0 && wphase) ? 4 : 0);
               if (bus_len != 2'd0) wphase = ~wphase;
               for (int k = 0; k < 4; k++)
                  if (bus_be[k]) bmem[(a + k) % 64] = bus_wdata[8*k +: 8];
            end else begin
               pend_addr = int'(bus_addr);
               pend_cnt  = int'(bus_len) + 1;
            end
         end
         @(negedge clk);
         bus_ready = (cyc % 3 != 1);
         rsp_valid = (pend_cnt > 0) && (cyc % 4 != 2);
         rsp_rdata = rsp_valid ? bword(pend_addr) : 32'h0;
      end
   end

   task automatic run_req(input bit wr, input int sz, input int addr,
                          input logic [63:0] wd, output logic [63:0] rd,
                          output int hs, output int l1, output bit busy_ok);
      int hs0, l10, tmo;
      hs0 = hs_total;
      l10 = len1_total;
      busy_ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_size  = 2'(sz);
      req_addr  = AW'(addr);
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      tmo = 0;
      while (!done_valid && tmo < 300) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         tmo++;
      end
      if (!done_valid) chk(1'b0, "watchdog request", 64'(tmo), 64'd0);
      rd = done_rdata;
      hs = hs_total - hs0;
      l1 = len1_total - l10;
   endtask

   task automatic do_read(input int sz, input int addr, input int o4, input int n,
                          input int nb);
      logic [63:0] rd, exp;
      int hs, l1;
      bit busy_ok;
      run_req(1'b0, sz, addr, 64'h0, rd, hs, l1, busy_ok);
      exp = '0;
      for (int i = 0; i < n; i++) exp[8*i +: 8] = rmem[addr + i];
      chk(rd == exp, "R1/R5 load value", rd, exp);
      chk(hs == ((o4 == 0) ? 1 : nb), "R3/R4 load transaction count",
          64'(hs), 64'((o4 == 0) ? 1 : nb));
      chk(l1 == ((o4 == 0 && n == 8) ? 1 : 0), "R3 load length field",
          64'(l1), 64'((o4 == 0 && n == 8) ? 1 : 0));
      chk(busy_ok, "R8 req_ready low while busy", 64'(busy_ok), 64'd1);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) rmem[i] = 8'((i * 37 + 5) % 256);
      repeat (4) @(negedge clk);
      // R9: idle outputs during and right after reset
      chk(req_ready == 1'b1 && bus_valid == 1'b0 && done_valid == 1'b0,
          "R9 reset state", {61'd0, req_ready, bus_valid, done_valid}, 64'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_valid == 1'b0 && done_valid == 1'b0,
          "R9 after reset", {61'd0, req_ready, bus_valid, done_valid}, 64'h4);

      for (int sz = 0; sz < 4; sz++) begin
         for (int off = 0; off < 8; off++) begin
            int addr, n, o4, nb, hs, l1, diffs;
            logic [63:0] wd, rd;
            bit busy_ok;
            addr = 8 * sz + off + 8;
            n    = 1 << sz;
            o4   = addr % 4;
            nb   = (o4 + n + 3) / 4;
            do_read(sz, addr, o4, n, nb);

            // store with junk above the access width (R6 says it is ignored)
            wd = 64'hA1B2_C3D4_E5F6_0718 ^ {8{8'(addr * 13 + sz)}};
            for (int i = 0; i < n; i++) rmem[addr + i] = wd[8*i +: 8];
            run_req(1'b1, sz, addr, wd, rd, hs, l1, busy_ok);
            diffs = 0;
            for (int i = 0; i < 64; i++) if (bmem[i] !== rmem[i]) diffs++;
            chk(diffs == 0, "R6 memory after store", 64'(diffs), 64'd0);
            chk(rd == 64'd0, "R8 store completion data", rd, 64'd0);
            chk(hs == nb, "R3/R4 store beat count", 64'(hs), 64'(nb));
            chk(l1 == ((o4 == 0 && n == 8) ? 2 : 0), "R3 store length field",
                64'(l1), 64'((o4 == 0 && n == 8) ? 2 : 0));
            chk(busy_ok, "R8 store busy", 64'(busy_ok), 64'd1);

            do_read(sz, addr, o4, n, nb);
         end
      end

      // R8: completion is a single-cycle pulse
      @(negedge clk);
      chk(done_valid == 1'b0, "R8 pulse ends", 64'(done_valid), 64'd0);
      // R2, R7 are also guarded by the design's own assertions during the sweep
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule